// File: doc/BRIEF.md
# Line Printer Character Formatter

This block sits between a stream of character codes and a printer whose line holds 132 columns. Each accepted code becomes zero or more output characters and, where needed, one request to the vertical format unit. That request is either a single-line advance or a skip to top of form. Horizontal position is tracked in a column counter. A tab is expanded into spaces up to the next stop. A full line wraps by itself before the next printable character goes out. Control codes with no formatting meaning are printed as spaces.

All three streams use valid/ready. An output, either a character or a vertical request, is offered with its valid high and its data steady until the consumer raises ready. A transfer takes place on a rising clock edge where both valid and ready are high. The producer of a code must hold `code_valid` and `code_data` steady until `code_ready` is seen. `code_ready` goes high only in the cycle where the last output belonging to that code is transferred. A code that produces no output is acknowledged in the same cycle it is offered. The column counter takes its new value on the edge that acknowledges the code. The vertical table itself lives in the downstream unit.

Top module: `lpf_formatter`

## Requirements
- R1: After reset the column is 0, `char_valid`, `vfu_valid` and `code_ready` are low until a code is offered.
- R2: Only the low 7 bits of `code_data` are used. A code whose low 7 bits are 0 is acknowledged at once, produces no output and leaves the column unchanged.
- R3: Code 0x0A issues one vertical request with `vfu_top`=0, outputs no character, and leaves the column at 0.
- R4: Code 0x0C issues one vertical request with `vfu_top`=1 (skip to top of form), outputs no character, and leaves the column at 0.
- R5: Code 0x0D clears the column, then outputs the character 0x0D, so the column ends at 1.
- R6: Code 0x09 at a column below 128 outputs 8 − (column mod 8) spaces (0x20), moving the column to the next multiple of 8.
- R7: Code 0x09 at column 128 or above first issues a line advance (`vfu_top`=0), then outputs 8 spaces, leaving the column at 8.
- R8: Any other code below 0x20 is output as one space (0x20). No character below 0x20 other than 0x0D ever leaves the block.
- R9: A printable code, or a code converted to a space, that arrives at column 132 or above first issues a line advance and is then output, leaving the column at 1. The column never exceeds 132.
- R10: A printable code (0x20 to 0x7F) at a column below 132 is output unchanged. The column grows by exactly the number of characters output and changes only when a code is acknowledged.
- R11: An offered output keeps its valid high and its data stable until ready. A character and a vertical request are never offered together. A vertical request always precedes the characters of the same code. `code_ready` rises only when the last output of the code is transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_valid | input | 1 | Input code offered |
| code_ready | output | 1 | Input code consumed (all its output done) |
| code_data | input | 8 | Input code; bit 7 ignored |
| char_valid | output | 1 | Output character offered |
| char_ready | input | 1 | Printer accepts the character |
| char_data | output | 7 | Output character |
| vfu_valid | output | 1 | Vertical request offered |
| vfu_ready | input | 1 | Vertical format unit accepts the request |
| vfu_top | output | 1 | 1: skip to top of form, 0: advance one line |
| column | output | 8 | Current column counter |

## Verification
Plain printable runs are first driven from column 0 past the 132-column limit. This separates the ordinary count-by-one path from the automatic wrap, which must place its line advance ahead of the character. Tabs are sent from several column offsets: mid-stop, exactly on a stop, at 128 reached through sixteen tabs, and at 130. These patterns distinguish the variable space count from the forced-advance-then-eight rule. Carriage return, line feed, form feed, an unnamed control code, a code with bit 7 set and a zero code then show the cases that produce no output, a single output or a request only. All of this runs once with free-flowing consumers and once under pseudo-random stalls on both outputs, so early acknowledgement or dropped held data shows up as a queue mismatch.

// File: rtl/lpf_pkg.sv
package lpf_pkg;

  localparam int CHAR_W = 7;

  localparam logic [CHAR_W-1:0] K_NUL   = 7'h00;
  localparam logic [CHAR_W-1:0] K_TAB   = 7'h09;
  localparam logic [CHAR_W-1:0] K_LF    = 7'h0A;
  localparam logic [CHAR_W-1:0] K_FF    = 7'h0C;
  localparam logic [CHAR_W-1:0] K_CR    = 7'h0D;
  localparam logic [CHAR_W-1:0] K_SPACE = 7'h20;

  typedef enum logic [1:0] {
    ADV_NONE = 2'd0,
    ADV_LINE = 2'd1,
    ADV_TOP  = 2'd2
  } adv_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_VFU  = 2'd1,
    ST_EMIT = 2'd2
  } seq_state_e;

endpackage

// File: rtl/lpf_classify.sv
module lpf_classify
  import lpf_pkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int COL_W      = 8,
  parameter int LINE_WIDTH = 132,
  parameter int TAB_STOP   = 8,
  parameter int TAB_WRAP   = 128,
  localparam int TAB_LG    = $clog2(TAB_STOP),
  localparam int CNT_W     = $clog2(TAB_STOP + 1)
) (
  input  logic [CODE_W-1:0] code,
  input  logic [COL_W-1:0]  col,
  output adv_e              adv,
  output logic [CHAR_W-1:0] ch,
  output logic [CNT_W-1:0]  count,
  output logic [COL_W-1:0]  next_col
);

  logic [CHAR_W-1:0] c7;
  logic [TAB_LG-1:0] col_lo;
  logic [COL_W-1:0]  base;
  logic              unused_hi;

  assign c7        = code[CHAR_W-1:0];
  assign col_lo    = col[TAB_LG-1:0];
  assign unused_hi = ^code[CODE_W-1:CHAR_W];

  always_comb begin
    adv   = ADV_NONE;
    ch    = K_SPACE;
    count = '0;
    base  = col;
    if (c7 == K_NUL) begin
      // nothing to do
    end else if (c7 == K_LF) begin
      adv  = ADV_LINE;
      base = '0;
    end else if (c7 == K_FF) begin
      adv  = ADV_TOP;
      base = '0;
    end else if (c7 == K_CR) begin
      ch    = K_CR;
      count = CNT_W'(1);
      base  = '0;
    end else if (c7 == K_TAB) begin
      if (col >= COL_W'(TAB_WRAP)) begin
        adv   = ADV_LINE;
        base  = '0;
        count = CNT_W'(TAB_STOP);
      end else begin
        count = CNT_W'(TAB_STOP) - CNT_W'(col_lo);
      end
    end else begin
      ch    = (c7 < K_SPACE) ? K_SPACE : c7;
      count = CNT_W'(1);
      if (col >= COL_W'(LINE_WIDTH)) begin
        adv  = ADV_LINE;
        base = '0;
      end
    end
    next_col = base + COL_W'(count);
  end

endmodule

// File: rtl/lpf_column.sv
module lpf_column #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [COL_W-1:0] next_col,
  output logic [COL_W-1:0] col
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    col <= '0;
    else if (load) col <= next_col;
  end

endmodule

// File: rtl/lpf_seq.sv
module lpf_seq
  import lpf_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  adv_e             adv,
  input  logic [CNT_W-1:0] count,
  input  logic             out_ready,
  input  logic             req_ready,
  output logic             out_valid,
  output logic             req_valid,
  output logic             req_top,
  output logic             ack
);

  seq_state_e       state, state_nx;
  logic [CNT_W-1:0] rem, rem_nx;
  logic             has_chars;

  assign has_chars = (count != '0);

  always_comb begin
    state_nx = state;
    rem_nx   = rem;
    ack      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (in_valid) begin
          if (adv != ADV_NONE) begin
            state_nx = ST_VFU;
          end else if (has_chars) begin
            state_nx = ST_EMIT;
            rem_nx   = count;
          end else begin
            ack = 1'b1;
          end
        end
      end
      ST_VFU: begin
        if (req_ready) begin
          if (has_chars) begin
            state_nx = ST_EMIT;
            rem_nx   = count;
          end else begin
            state_nx = ST_IDLE;
            ack      = 1'b1;
          end
        end
      end
      ST_EMIT: begin
        if (out_ready) begin
          if (rem == CNT_W'(1)) begin
            state_nx = ST_IDLE;
            ack      = 1'b1;
          end
          rem_nx = rem - CNT_W'(1);
        end
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      rem   <= '0;
    end else begin
      state <= state_nx;
      rem   <= rem_nx;
    end
  end

  assign out_valid = (state == ST_EMIT);
  assign req_valid = (state == ST_VFU);
  assign req_top   = (adv == ADV_TOP);

endmodule

// File: rtl/lpf_formatter.sv
module lpf_formatter
  import lpf_pkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int COL_W      = 8,
  parameter int LINE_WIDTH = 132,
  parameter int TAB_STOP   = 8,
  parameter int TAB_WRAP   = 128,
  localparam int CNT_W     = $clog2(TAB_STOP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_valid,
  output logic              code_ready,
  input  logic [CODE_W-1:0] code_data,
  output logic              char_valid,
  input  logic              char_ready,
  output logic [6:0]        char_data,
  output logic              vfu_valid,
  input  logic              vfu_ready,
  output logic              vfu_top,
  output logic [COL_W-1:0]  column
);

  adv_e              adv;
  logic [CHAR_W-1:0] ch;
  logic [CNT_W-1:0]  count;
  logic [COL_W-1:0]  next_col;
  logic              ack;

  lpf_classify #(
    .CODE_W(CODE_W), .COL_W(COL_W), .LINE_WIDTH(LINE_WIDTH),
    .TAB_STOP(TAB_STOP), .TAB_WRAP(TAB_WRAP)
  ) u_classify (
    .code(code_data), .col(column), .adv(adv), .ch(ch),
    .count(count), .next_col(next_col)
  );

  lpf_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(code_valid), .adv(adv),
    .count(count), .out_ready(char_ready), .req_ready(vfu_ready),
    .out_valid(char_valid), .req_valid(vfu_valid), .req_top(vfu_top),
    .ack(ack)
  );

  lpf_column #(.COL_W(COL_W)) u_column (
    .clk(clk), .rst_n(rst_n), .load(ack), .next_col(next_col), .col(column)
  );

  assign code_ready = ack;
  assign char_data  = ch;

endmodule

// File: rtl/lpf_formatter_chk.sv
module lpf_formatter_chk #(
  parameter int COL_W      = 8,
  parameter int LINE_WIDTH = 132
) (
  input logic             clk,
  input logic             rst_n,
  input logic             code_valid,
  input logic             code_ready,
  input logic             char_valid,
  input logic             char_ready,
  input logic [6:0]       char_data,
  input logic             vfu_valid,
  input logic             vfu_ready,
  input logic             vfu_top,
  input logic [COL_W-1:0] column
);

  AST_CHAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid && !char_ready |=> char_valid && $stable(char_data)); // R11
  AST_VFU_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    vfu_valid && !vfu_ready |=> vfu_valid && $stable(vfu_top)); // R11
  AST_ONE_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    !(char_valid && vfu_valid)); // R11
  AST_ACK_NEEDS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    code_ready |-> code_valid); // R11
  AST_COL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(code_valid && code_ready) |=> $stable(column)); // R10
  AST_COL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    column <= COL_W'(LINE_WIDTH)); // R9
  AST_NO_RAW_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid |-> (char_data >= 7'h20 || char_data == 7'h0D)); // R8

endmodule

bind lpf_formatter lpf_formatter_chk #(.COL_W(COL_W), .LINE_WIDTH(LINE_WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .code_valid(code_valid), .code_ready(code_ready),
  .char_valid(char_valid), .char_ready(char_ready), .char_data(char_data),
  .vfu_valid(vfu_valid), .vfu_ready(vfu_ready), .vfu_top(vfu_top),
  .column(column)
);

// File: tb/test_lpf_formatter.sv
module test_lpf_formatter;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       code_valid = 1'b0;
  logic       code_ready;
  logic [7:0] code_data = 8'h00;
  logic       char_valid;
  logic       char_ready = 1'b0;
  logic [6:0] char_data;
  logic       vfu_valid;
  logic       vfu_ready = 1'b0;
  logic       vfu_top;
  logic [7:0] column;

  int checks = 0;
  int errors = 0;
  int model_col = 0;
  int exp_q[$];
  string req_q[$];
  bit stall_mode = 1'b0;
  bit done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  lpf_formatter i_lpf_formatter (
    .clk(clk), .rst_n(rst_n), .code_valid(code_valid), .code_ready(code_ready),
    .code_data(code_data), .char_valid(char_valid), .char_ready(char_ready),
    .char_data(char_data), .vfu_valid(vfu_valid), .vfu_ready(vfu_ready),
    .vfu_top(vfu_top), .column(column)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected item: 0x000+ch for a character, 0x100 line advance, 0x200 top of form
  task automatic push_item(int item, string req);
    exp_q.push_back(item);
    req_q.push_back(req);
  endtask

  task automatic model(logic [7:0] code, string req);
    int c;
    int n;
    c = int'(code[6:0]);
    if (c == 0) begin
    end else if (c == 'h0A) begin
      push_item('h100, req); model_col = 0;
    end else if (c == 'h0C) begin
      push_item('h200, req); model_col = 0;
    end else if (c == 'h0D) begin
      push_item('h0D, req); model_col = 1;
    end else if (c == 'h09) begin
      if (model_col >= 128) begin
        push_item('h100, req); model_col = 0; n = 8;
      end else n = 8 - (model_col % 8);
      for (int k = 0; k < n; k++) push_item('h20, req);
      model_col += n;
    end else begin
      if (model_col >= 132) begin
        push_item('h100, req); model_col = 0;
      end
      push_item((c < 'h20) ? 'h20 : c, req);
      model_col += 1;
    end
  endtask

  task automatic send(logic [7:0] code, string req);
    model(code, req);
    @(negedge clk);
    code_data  = code;
    code_valid = 1'b1;
    forever begin
      #1;
      if (code_ready) break;
      @(negedge clk);
    end
    check(exp_q.size() == 0, "R11", "outputs pending at acknowledge", exp_q.size(), 0);
    @(posedge clk);
    #1 code_valid = 1'b0;
    @(negedge clk);
    check(int'(column) == model_col, req, "column", int'(column), model_col);
  endtask

  // Monitor: choose ready for the coming edge, then score any transfer it makes
  initial begin
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      char_ready = stall_mode ? (lfsr[0] | lfsr[3]) : 1'b1;
      vfu_ready  = stall_mode ? lfsr[5] : 1'b1;
      if (rst_n) begin
        if (char_valid && vfu_valid)
          check(1'b0, "R11", "char and vfu offered together", 1, 0);
        if ((char_valid && char_ready) || (vfu_valid && vfu_ready)) begin
          int got;
          got = (vfu_valid && vfu_ready) ? (vfu_top ? 'h200 : 'h100) : int'(char_data);
          if (exp_q.size() == 0) begin
            check(1'b0, "R11", "unexpected output", got, -1);
          end else begin
            int want;
            string r;
            want = exp_q.pop_front();
            r = req_q.pop_front();
            check(got == want, r, "output item", got, want);
          end
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog actual=hung expected=complete");
    finish_run();
  end

  task automatic run_suite();
    send(8'h0D, "R5");
    send(8'h80, "R2");
    send(8'h00, "R2");
    send(8'h41, "R10");
    send(8'h7F, "R10");
    send(8'h09, "R6");
    send(8'h09, "R6");
    send(8'h0D, "R5");
    send(8'h09, "R6");
    send(8'h07, "R8");
    send(8'h1B, "R8");
    send(8'h0A, "R3");
    send(8'h0C, "R4");
    send(8'h8A, "R2");
    for (int i = 0; i < 132; i++) send(8'h41 + 8'(i % 26), "R10");
    send(8'h5A, "R9");
    for (int i = 0; i < 131; i++) send(8'h61 + 8'(i % 26), "R10");
    send(8'h01, "R9");
    send(8'h0A, "R3");
    for (int i = 0; i < 16; i++) send(8'h09, "R6");
    send(8'h09, "R7");
    send(8'h0A, "R3");
    for (int i = 0; i < 16; i++) send(8'h09, "R6");
    send(8'h62, "R10");
    send(8'h63, "R10");
    send(8'h09, "R7");
    send(8'h0C, "R4");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(column == 8'd0, "R1", "column in reset", int'(column), 0);
    check(!char_valid && !vfu_valid, "R1", "valids in reset", int'({char_valid, vfu_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(column == 8'd0, "R1", "column after reset", int'(column), 0);
    check(!char_valid && !vfu_valid && !code_ready, "R1", "idle outputs",
          int'({char_valid, vfu_valid, code_ready}), 0);
    run_suite();
    stall_mode = 1'b1;
    run_suite();
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R11", "leftover expected items", exp_q.size(), 0);
    finish_run();
  end

endmodule